// File: doc/BRIEF.md
# Flash Block Protection and Security Checker

This block decides whether a program or erase request may touch a flash array split into 64K blocks. After reset it takes in a stream of configuration bytes. Four of these bytes set per-block protection rules and one sets the security state. From then on it judges every request, given as a block index, a byte offset inside the block and a mass-erase flag. A refused request raises a sticky violation flag that stays set until the clear input is pulsed. A separate output reports whether the device is secured, based on the two low bits of the security byte.

Each block has two protected areas that can be enabled on their own. The upper area grows downward from the top of the block. The lower area grows upward from the block's midpoint. A master enable bit in the protection byte either locks the whole block or hands the decision to the two area rules.

The configuration input is a valid/ready stream. `cfg_ready` is high from reset until the byte flagged `cfg_last` is accepted, then it stays low, and any bytes offered after that are not taken. The request side has no back-pressure: a request is accepted in every cycle that `req_valid` is high. Its verdict appears on the response pins one cycle later.

Top module: `fprot_guard`

## Requirements
- R1: After reset `cfg_ready` is 1. Each configuration byte is taken when `cfg_valid` and `cfg_ready` are both high. A byte at address 0xFF0A sets the protection byte of block 3, 0xFF0B sets block 2, 0xFF0C sets block 1 and 0xFF0D sets block 0. A byte at 0xFF0F sets the security code. Bytes at any other address are ignored. Taking the byte flagged `cfg_last` completes the load. After that `cfg_ready` is 0, and later bytes change no protection or security state.
- R2: Protection byte bit 7 is the block enable. When it is 0, every program request and every mass erase to that block is refused, whatever the other bits hold.
- R3: When bit 7 is 1 and bit 6 (upper-area disable) is 0, the upper area is protected. Its size is selected by bits 5:4: code 00 gives 2K, 01 gives 4K, 10 gives 8K and 11 gives 16K, measured down from offset 0x10000. An offset inside the area is refused. The offset just below it is allowed.
- R4: When bit 7 is 1 and bit 3 (lower-area disable) is 0, the lower area is protected. Its size is selected by bits 1:0: code 00 gives 512B, 01 gives 1K, 10 gives 2K and 11 gives 4K, starting at offset 0x8000 and growing upward. Offset 0x7FFF and offset 0x8000+size are allowed. Bit 2 has no effect.
- R5: A disable bit at 1 leaves its area unprotected whatever its size code holds.
- R6: A request made with `req_valid` high at one clock edge is answered at the next edge with `rsp_valid`=1. `rsp_ok` is 1 if the request was allowed and 0 if it was refused. A refusal by the protection rules sets `viol_flag` at that same edge.
- R7: `viol_flag` stays set until a cycle in which `viol_clr` is 1 and no new violation occurs. If a violation and `viol_clr` come in the same cycle, the flag stays set.
- R8: A mass erase (`req_mass`=1) is allowed only when bits 7, 6 and 3 are all 1. The offset is ignored for a mass erase.
- R9: Until the load completes, every request is answered with `rsp_ok`=0 and `rsp_not_ready`=1, and `viol_flag` is left unchanged.
- R10: `secured` is 0 only when the two low bits of the loaded security byte are 10. Codes 00, 01 and 11 read as secured. From reset until a security byte is loaded, `secured` is 1.
- R11: During and right after reset, `rsp_valid`, `rsp_ok`, `rsp_not_ready` and `viol_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration byte valid |
| cfg_ready | output | 1 | High while configuration bytes are being taken |
| cfg_addr | input | 16 | Configuration byte address |
| cfg_data | input | 8 | Configuration byte value |
| cfg_last | input | 1 | Marks the final configuration byte |
| req_valid | input | 1 | Program/erase request strobe |
| req_blk | input | 2 | Target block index |
| req_ofs | input | 16 | Byte offset within the 64K block |
| req_mass | input | 1 | Request is a mass erase of the block |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_ok | output | 1 | Request allowed |
| rsp_not_ready | output | 1 | Request refused because the load has not completed |
| viol_flag | output | 1 | Sticky protection-violation flag |
| viol_clr | input | 1 | Clears viol_flag when 1 |
| secured | output | 1 | 1 when the device is secured |

## Verification
Suppose a protection byte is latched into the wrong block, or the reserved bit is decoded. Then the first request that lands on that block's area boundaries gets the wrong verdict, exactly one cycle after it is issued. So the bench probes the exact first and last protected offsets of each size code. A load sequencer that never finishes, or finishes too early, shows up on the next request as a wrong `rsp_not_ready` and on `cfg_ready` at once. A flag that fails to hold or to clear shows up on `viol_flag` in the cycle that follows the clear or the next harmless request.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
  // One block's protection rule byte, most significant field first.
  typedef struct packed {
    logic       blk_en;   // 0: whole block locked
    logic       hi_free;  // 1: upper area unprotected
    logic [1:0] hi_code;  // upper area size code
    logic       lo_free;  // 1: lower area unprotected
    logic       lo_rsv;   // carries no meaning
    logic [1:0] lo_code;  // lower area size code
  } prot_t;

  localparam int unsigned PROT_BITS = $bits(prot_t);
endpackage

// File: rtl/fprot_cfg_loader.sv
module fprot_cfg_loader
  import fprot_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int CFG_AW     = 16,
  parameter int PROT_BASE  = 'hFF0A,
  parameter int SEC_ADDR   = 'hFF0F
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_valid,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [PROT_BITS-1:0]  cfg_data,
  input  logic                  cfg_last,
  output logic                  cfg_ready,
  output logic                  load_done,
  output prot_t [NUM_BLOCKS-1:0] prot_q,
  output logic [1:0]            sec_q
);
  localparam logic [CFG_AW-1:0] SEC_A = CFG_AW'(SEC_ADDR);

  logic take;
  assign cfg_ready = !load_done;
  assign take      = cfg_valid && cfg_ready;

  // Highest-numbered block sits at the lowest configuration address.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q    <= '1;
      sec_q     <= 2'b11;
      load_done <= 1'b0;
    end else if (take) begin
      for (int k = 0; k < NUM_BLOCKS; k++) begin
        if (cfg_addr == CFG_AW'(PROT_BASE + NUM_BLOCKS - 1 - k))
          prot_q[k] <= cfg_data;
      end
      if (cfg_addr == SEC_A)
        sec_q <= cfg_data[1:0];
      if (cfg_last)
        load_done <= 1'b1;
    end
  end
endmodule

// File: rtl/fprot_area_check.sv
module fprot_area_check #(
  parameter int OFS_W   = 16,
  parameter int HI_UNIT = 2048,
  parameter int LO_UNIT = 512
) (
  input  logic             blk_en,
  input  logic             hi_free,
  input  logic [1:0]       hi_code,
  input  logic             lo_free,
  input  logic [1:0]       lo_code,
  input  logic [OFS_W-1:0] ofs,
  input  logic             mass,
  output logic             deny
);
  localparam logic [OFS_W:0] SPAN    = {1'b1, {OFS_W{1'b0}}};
  localparam logic [OFS_W:0] MID     = SPAN >> 1;
  localparam logic [OFS_W:0] HI_BASE = (OFS_W + 1)'(HI_UNIT);
  localparam logic [OFS_W:0] LO_BASE = (OFS_W + 1)'(LO_UNIT);

  logic [OFS_W:0] pos, hi_len, lo_len;
  logic           hi_hit, lo_hit;

  always_comb begin
    pos    = {1'b0, ofs};
    hi_len = HI_BASE << hi_code;
    lo_len = LO_BASE << lo_code;
    hi_hit = !hi_free && (pos >= SPAN - hi_len);
    lo_hit = !lo_free && (pos >= MID) && (pos < MID + lo_len);
    if (!blk_en)   deny = 1'b1;
    else if (mass) deny = !(hi_free && lo_free);
    else           deny = hi_hit || lo_hit;
  end
endmodule

// File: rtl/fprot_guard.sv
module fprot_guard
  import fprot_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int OFS_W      = 16,
  parameter int CFG_AW     = 16,
  parameter int PROT_BASE  = 'hFF0A,
  parameter int SEC_ADDR   = 'hFF0F,
  parameter int HI_UNIT    = 2048,
  parameter int LO_UNIT    = 512,
  parameter int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_valid,
  output logic                 cfg_ready,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [PROT_BITS-1:0] cfg_data,
  input  logic                 cfg_last,
  input  logic                 req_valid,
  input  logic [BLK_W-1:0]     req_blk,
  input  logic [OFS_W-1:0]     req_ofs,
  input  logic                 req_mass,
  output logic                 rsp_valid,
  output logic                 rsp_ok,
  output logic                 rsp_not_ready,
  output logic                 viol_flag,
  input  logic                 viol_clr,
  output logic                 secured
);
  prot_t [NUM_BLOCKS-1:0] prot_q;
  logic [1:0]             sec_q;
  logic                   load_done;
  logic [NUM_BLOCKS-1:0]  deny_vec;
  logic                   sel_deny, hit_viol;

  fprot_cfg_loader #(
    .NUM_BLOCKS(NUM_BLOCKS), .CFG_AW(CFG_AW),
    .PROT_BASE(PROT_BASE), .SEC_ADDR(SEC_ADDR)
  ) i_loader (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_last(cfg_last), .cfg_ready(cfg_ready),
    .load_done(load_done), .prot_q(prot_q), .sec_q(sec_q)
  );

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_chk
    fprot_area_check #(
      .OFS_W(OFS_W), .HI_UNIT(HI_UNIT), .LO_UNIT(LO_UNIT)
    ) i_area (
      .blk_en(prot_q[g].blk_en), .hi_free(prot_q[g].hi_free),
      .hi_code(prot_q[g].hi_code), .lo_free(prot_q[g].lo_free),
      .lo_code(prot_q[g].lo_code), .ofs(req_ofs), .mass(req_mass),
      .deny(deny_vec[g])
    );
  end

  assign sel_deny = (int'(req_blk) < NUM_BLOCKS) ? deny_vec[req_blk] : 1'b1;
  assign hit_viol = req_valid && load_done && sel_deny;
  assign secured  = (sec_q != 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_ok        <= 1'b0;
      rsp_not_ready <= 1'b0;
      viol_flag     <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_ok        <= req_valid && load_done && !sel_deny;
      rsp_not_ready <= req_valid && !load_done;
      if (hit_viol)      viol_flag <= 1'b1;
      else if (viol_clr) viol_flag <= 1'b0;
    end
  end

  // R1: rules are frozen once the load has completed
  a_r1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |=> ($stable(prot_q) && $stable(sec_q)));
  // R9: requests before load completion come back as not ready
  a_r9_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !load_done) |=> (rsp_valid && rsp_not_ready && !rsp_ok));
  // R6: a protection refusal always leaves the flag raised
  a_r6_flag_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok && !rsp_not_ready) |-> viol_flag);
  // R7: the flag holds without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_clr) |=> viol_flag);
endmodule

// File: tb/test_fprot_guard.sv
module test_fprot_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0, cfg_last = 1'b0, cfg_ready;
  logic [15:0] cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic        req_valid = 1'b0, req_mass = 1'b0, viol_clr = 1'b0;
  logic [1:0]  req_blk = '0;
  logic [15:0] req_ofs = '0;
  logic        rsp_valid, rsp_ok, rsp_not_ready, viol_flag, secured;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // bench model
  logic [7:0] m_prot [4];
  logic [1:0] m_sec;
  bit         m_loaded, m_viol;

  always #10 clk = ~clk;

  fprot_guard i_fprot_guard (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .cfg_last(cfg_last),
    .req_valid(req_valid), .req_blk(req_blk), .req_ofs(req_ofs),
    .req_mass(req_mass), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_not_ready(rsp_not_ready), .viol_flag(viol_flag),
    .viol_clr(viol_clr), .secured(secured)
  );

  function automatic bit mdl_deny(logic [7:0] p, int ofs, bit mass);
    bit hi, lo;
    if (!p[7]) return 1'b1;
    if (mass) return !(p[6] && p[3]);
    hi = !p[6] && (ofs >= 65536 - (2048 << p[5:4]));
    lo = !p[3] && (ofs >= 32768) && (ofs < 32768 + (512 << p[1:0]));
    return hi || lo;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) m_prot[k] = 8'hFF;
    m_sec = 2'b11; m_loaded = 1'b0; m_viol = 1'b0;
    @(negedge clk);
  endtask

  task automatic cfg_byte(logic [15:0] a, logic [7:0] d, bit last);
    cfg_valid = 1'b1; cfg_addr = a; cfg_data = d; cfg_last = last;
    if (!m_loaded) begin
      if (a >= 16'hFF0A && a <= 16'hFF0D) m_prot[3 - (a - 16'hFF0A)] = d;
      if (a == 16'hFF0F) m_sec = d[1:0];
      if (last) m_loaded = 1'b1;
    end
    @(negedge clk);
    cfg_valid = 1'b0; cfg_last = 1'b0;
  endtask

  task automatic do_req(string tag, int blk, int ofs, bit mass, bit clr);
    bit d, e_ok, e_nr;
    req_valid = 1'b1; req_blk = 2'(blk); req_ofs = 16'(ofs);
    req_mass = mass; viol_clr = clr;
    d    = mdl_deny(m_prot[blk], ofs, mass);
    e_nr = !m_loaded;
    e_ok = m_loaded && !d;
    if (m_loaded && d) m_viol = 1'b1;
    else if (clr)      m_viol = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; req_mass = 1'b0; viol_clr = 1'b0;
    check(tag, "rsp_valid", rsp_valid, 1);
    check(tag, "rsp_ok", rsp_ok, e_ok);
    check(tag, "rsp_not_ready", rsp_not_ready, e_nr);
    check(tag, "viol_flag", viol_flag, m_viol);
  endtask

  task automatic clr_only(string tag);
    viol_clr = 1'b1;
    @(negedge clk);
    viol_clr = 1'b0;
    m_viol = 1'b0;
    check(tag, "viol_flag after clear", viol_flag, 0);
    check(tag, "rsp_valid idle", rsp_valid, 0);
  endtask

  function automatic int pick_ofs();
    int base;
    case ($urandom % 4)
      0: base = int'($urandom % 65536);
      1: base = 65536 - (2048 << ($urandom % 4)) + int'($urandom % 3) - 1;
      2: base = 32768 + (512 << ($urandom % 4)) + int'($urandom % 3) - 1;
      default: base = 32767 + int'($urandom % 2);
    endcase
    return base & 16'hFFFF;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R11 / R10 reset state
    check("R11", "rsp_valid", rsp_valid, 0);
    check("R11", "viol_flag", viol_flag, 0);
    check("R1", "cfg_ready at reset", cfg_ready, 1);
    check("R10", "secured at reset", secured, 1);
    // R9 request before load
    do_req("R9", 0, 16'h0100, 1'b0, 1'b0);
    // R1 load with ignored addresses
    cfg_byte(16'hFF0A, 8'h7F, 1'b0);
    cfg_byte(16'hFF0B, 8'h98, 1'b0);
    cfg_byte(16'h1234, 8'h00, 1'b0);
    cfg_byte(16'hFF0E, 8'h00, 1'b0);
    cfg_byte(16'hFF0C, 8'hC2, 1'b0);
    cfg_byte(16'hFF0D, 8'hFF, 1'b0);
    check("R1", "cfg_ready before last", cfg_ready, 1);
    cfg_byte(16'hFF0F, 8'hFE, 1'b1);
    check("R1", "cfg_ready after last", cfg_ready, 0);
    check("R10", "secured code 10", secured, 0);
    // R1 late byte is ignored
    cfg_byte(16'hFF0D, 8'h00, 1'b1);
    do_req("R1", 0, 16'hFFFF, 1'b0, 1'b0);
    // R2 locked block
    do_req("R2", 3, 16'h0000, 1'b0, 1'b0);
    clr_only("R7");
    do_req("R2", 3, 16'h0000, 1'b1, 1'b0);
    clr_only("R7");
    // R3 upper area 4K on block 2
    do_req("R3", 2, 16'hEFFF, 1'b0, 1'b0);
    do_req("R3", 2, 16'hF000, 1'b0, 1'b0);
    do_req("R3", 2, 16'hFFFF, 1'b0, 1'b0);
    clr_only("R7");
    do_req("R5", 2, 16'h8000, 1'b0, 1'b0);
    do_req("R8", 2, 16'h0000, 1'b1, 1'b0);
    clr_only("R7");
    // R4 lower area 2K on block 1
    do_req("R4", 1, 16'h7FFF, 1'b0, 1'b0);
    do_req("R4", 1, 16'h8000, 1'b0, 1'b0);
    do_req("R4", 1, 16'h87FF, 1'b0, 1'b1);
    do_req("R4", 1, 16'h8800, 1'b0, 1'b0);
    do_req("R5", 1, 16'hFFFF, 1'b0, 1'b0);
    do_req("R8", 1, 16'h1234, 1'b1, 1'b0);
    // R7 holds across an allowed request, then clear, then set beats clear
    do_req("R7", 0, 16'h0010, 1'b0, 1'b0);
    clr_only("R7");
    do_req("R8", 0, 16'hABCD, 1'b1, 1'b0);
    do_req("R7", 3, 16'h4000, 1'b0, 1'b1);
    do_req("R6", 0, 16'h0000, 1'b0, 1'b1);
    // Second load: erased security byte is secured
    do_reset();
    cfg_byte(16'hFF0F, 8'hFF, 1'b1);
    check("R10", "secured code 11", secured, 1);
    // Random rounds
    for (int r = 0; r < 6; r++) begin
      do_reset();
      do_req("R9", int'($urandom % 4), pick_ofs(), 1'b0, 1'b0);
      for (int a = 0; a < 4; a++)
        cfg_byte(16'hFF0A + 16'(a), 8'($urandom), 1'b0);
      cfg_byte(16'hFF0F, 8'($urandom), 1'b1);
      check("R10", "secured random", secured, m_sec != 2'b10);
      for (int n = 0; n < 120; n++)
        do_req("R6", int'($urandom % 4), pick_ofs(), ($urandom % 8) == 0,
               ($urandom % 5) == 0);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule